// File: doc/BRIEF.md
# Multiphase Edge Pulse Combiner

This block merges a set of evenly phase-shifted square waves into one fast pulse clock. It takes 4·k phases, with k a parameter set to 5 by default, which gives 20 phases 18° apart. Each phase is already a clean digital level, such as the output of a comparator, and may change at any time relative to the sampling clock. Each phase first passes through a two-flop synchronizer. A rising-edge detector then turns each rising edge into a pulse. The width of that pulse is a fixed, parameterized number of system-clock cycles, so it stays far narrower than the spacing between phases.

The per-phase pulses are merged by a two-level OR: first one OR per quadrant of k phases, then one OR over the four quadrant results. The merged result is registered and driven out as the multiplied clock. Every phase rises once per phase period, and that period spans two reference periods. So 4·k pulses appear every two reference periods, and the output runs at 2·k times the reference frequency.

For checking, a free-running counter advances on every output rising edge. A saturating counter records each episode in which pulses from two or more phases coincide and therefore merge into one output pulse.

Top module: `phase_pulse_combiner`

## Requirements
- R1: While reset is asserted, and on release, `mult_clk_out` is 0 and both `edge_cnt` and `overlap_cnt` are 0.
- R2: A rising edge on one phase input, set up before a system clock edge, makes `mult_clk_out` go high on the third rising clock edge and not earlier. The three stages are two synchronizer flops and the output register.
- R3: A rising phase edge that stays high for at least PULSE_CYC cycles gives an output pulse exactly PULSE_CYC clock cycles wide.
- R4: Falling edges and steady levels on the phase inputs produce no output pulse and leave `edge_cnt` unchanged.
- R5: Each of the 4·k phase inputs, driven alone, produces an output pulse.
- R6: Suppose all phases share a period P and their rising edges are spread evenly, at least PULSE_CYC+1 cycles apart. Then `edge_cnt` advances by exactly 4·k per period P. This is 2·k output edges per reference period, since P spans two reference periods.
- R7: `edge_cnt` advances by exactly one on each output rising edge, holds otherwise, and wraps modulo 2^EDGE_CNT_W.
- R8: Pulses from two or more phases in the same cycle give one merged output pulse (one edge counted). `overlap_cnt` rises by one for each episode in which such a coincidence begins.
- R9: `overlap_cnt` saturates at 2^OVL_CNT_W−1 and stays there.
- R10: During evenly spread, non-coinciding phase activity, `overlap_cnt` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_in | input | 4·SEGS | Digitized phase levels, index order equals phase order |
| mult_clk_out | output | 1 | Merged pulse clock |
| edge_cnt | output | EDGE_CNT_W | Count of output rising edges, wrapping |
| overlap_cnt | output | OVL_CNT_W | Saturating count of coincidence episodes |

## Verification
The embedded assertions check the following on every cycle:
- the synchronizer latency;
- that no detector pulse outlasts the programmed width;
- that the edge counter steps exactly on output rises and holds otherwise;
- that the overlap counter moves only in unit steps and stays put once saturated;
- that the output never pulses without a source pulse.

Some behaviour is visible only in the bench scenarios:
- the exact pulse width and three-cycle latency for each individual phase;
- the 4·k-edges-per-period rate over a sweep of phase spacings;
- edge-counter wraparound;
- the merging of coincident phases into one counted edge, with the overlap count climbing into saturation.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  // depth of the per-phase synchronizer
  localparam int unsigned SYNC_DEPTH = 2;
  // depth of the reset release synchronizer
  localparam int unsigned RST_DEPTH  = 2;
  // number of quadrants the phases are grouped into
  localparam int unsigned QUADS      = 4;
endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  import ppc_pkg::*;

  logic [SYNC_DEPTH-1:0][W-1:0] stg_q;
  logic [SYNC_DEPTH-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_in;
    for (int s = 1; s < SYNC_DEPTH; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_out = stg_q[SYNC_DEPTH-1];

  // cycles since reset, saturating at the synchronizer depth
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        warm_q <= '0;
    else if (warm_q != 2'(SYNC_DEPTH)) warm_q <= warm_q + 2'd1;
  end

  assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'(SYNC_DEPTH)) |-> (q_out == $past(d_in, SYNC_DEPTH)));
endmodule

// File: rtl/ppc_edge_det.sv
module ppc_edge_det #(
  parameter int unsigned W   = 20,
  parameter int unsigned DLY = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] pulse_out
);
  localparam int unsigned RUN_W = $clog2(DLY + 2);

  logic [DLY-1:0][W-1:0] dly_q;
  logic [DLY-1:0][W-1:0] dly_d;

  always_comb begin
    dly_d[0] = lvl_in;
    for (int s = 1; s < DLY; s++) dly_d[s] = dly_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  // high while the level is up but its delayed copy is still low
  assign pulse_out = lvl_in & ~dly_q[DLY-1];

  generate
    for (genvar b = 0; b < W; b++) begin : g_width_chk
      logic [RUN_W-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= '0;
        else if (!pulse_out[b]) run_q <= '0;
        else if (run_q != '1)   run_q <= run_q + 1'b1;
      end
      assert_pulse_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out[b] |-> (run_q < RUN_W'(DLY)));
    end
  endgenerate
endmodule

// File: rtl/ppc_or_tree.sv
module ppc_or_tree #(
  parameter int unsigned SEGS = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ppc_pkg::QUADS*SEGS-1:0]   pulses,
  output logic                             merged,
  output logic                             multi
);
  import ppc_pkg::*;
  localparam int unsigned N = QUADS * SEGS;

  logic [QUADS-1:0] quad_or;

  generate
    for (genvar g = 0; g < QUADS; g++) begin : g_quad
      assign quad_or[g] = |pulses[g*SEGS +: SEGS];
    end
  endgenerate

  assign merged = |quad_or;

  always_comb begin
    logic seen;
    seen  = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pulses[i]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
      end
    end
  end

  assert_multi_merged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    multi |-> merged);
endmodule

// File: rtl/phase_pulse_combiner.sv
module phase_pulse_combiner #(
  parameter int unsigned SEGS       = 5,
  parameter int unsigned PULSE_CYC  = 1,
  parameter int unsigned EDGE_CNT_W = 16,
  parameter int unsigned OVL_CNT_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ppc_pkg::QUADS*SEGS-1:0]    phase_in,
  output logic                              mult_clk_out,
  output logic [EDGE_CNT_W-1:0]             edge_cnt,
  output logic [OVL_CNT_W-1:0]              overlap_cnt
);
  import ppc_pkg::*;
  localparam int unsigned NPH = QUADS * SEGS;
  localparam logic [OVL_CNT_W-1:0] OVL_MAX = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [RST_DEPTH-1:0] rst_pipe_q;
  logic                 rst_loc_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_DEPTH-2:0], 1'b1};
  end
  assign rst_loc_n = rst_pipe_q[RST_DEPTH-1];

  logic [NPH-1:0] lvl_sync;
  logic [NPH-1:0] pulses;
  logic           merged;
  logic           multi;

  ppc_sync #(.W(NPH)) u_sync (
    .clk(clk), .rst_n(rst_loc_n), .d_in(phase_in), .q_out(lvl_sync)
  );

  ppc_edge_det #(.W(NPH), .DLY(PULSE_CYC)) u_edge (
    .clk(clk), .rst_n(rst_loc_n), .lvl_in(lvl_sync), .pulse_out(pulses)
  );

  ppc_or_tree #(.SEGS(SEGS)) u_tree (
    .clk(clk), .rst_n(rst_loc_n), .pulses(pulses), .merged(merged), .multi(multi)
  );

  // next state
  logic                  out_q, out_d;
  logic [EDGE_CNT_W-1:0] edge_q, edge_d;
  logic                  edge_en;
  logic [OVL_CNT_W-1:0]  ovl_q, ovl_d;
  logic                  ovl_en;
  logic                  multi_q;

  always_comb begin
    out_d   = merged;
    edge_en = merged & ~out_q;
    edge_d  = edge_q + 1'b1;
    ovl_en  = multi & ~multi_q & (ovl_q != OVL_MAX);
    ovl_d   = ovl_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_loc_n) begin
    if (!rst_loc_n) begin
      out_q   <= 1'b0;
      multi_q <= 1'b0;
      edge_q  <= '0;
      ovl_q   <= '0;
    end else begin
      out_q   <= out_d;
      multi_q <= multi;
      if (edge_en) edge_q <= edge_d;
      if (ovl_en)  ovl_q  <= ovl_d;
    end
  end

  assign mult_clk_out = out_q;
  assign edge_cnt     = edge_q;
  assign overlap_cnt  = ovl_q;

  assert_edge_step_R7: assert property (@(posedge clk) disable iff (!rst_loc_n)
    $rose(mult_clk_out) |-> (edge_cnt == EDGE_CNT_W'($past(edge_cnt) + 1'b1)));

  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_loc_n)
    !$rose(mult_clk_out) |-> $stable(edge_cnt));

  assert_ovl_unit_R8: assert property (@(posedge clk) disable iff (!rst_loc_n)
    (overlap_cnt != $past(overlap_cnt)) |-> (overlap_cnt == OVL_CNT_W'($past(overlap_cnt) + 1'b1)));

  assert_ovl_sat_R9: assert property (@(posedge clk) disable iff (!rst_loc_n)
    (overlap_cnt == OVL_MAX) |=> (overlap_cnt == OVL_MAX));

  assert_out_source_R5: assert property (@(posedge clk) disable iff (!rst_loc_n)
    mult_clk_out |-> $past(|pulses));
endmodule

// File: tb/tb_phase_pulse_combiner.sv
`timescale 1ns/1ps
module tb_phase_pulse_combiner;
  localparam int K = 5;
  localparam int N = 4 * K;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] ph = '0;
  logic         o_a, o_b;
  logic [7:0]   e_a, e_b;
  logic [2:0]   v_a, v_b;

  always #2.5 clk = ~clk;

  phase_pulse_combiner #(.SEGS(K), .PULSE_CYC(1), .EDGE_CNT_W(8), .OVL_CNT_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .phase_in(ph),
    .mult_clk_out(o_a), .edge_cnt(e_a), .overlap_cnt(v_a));

  phase_pulse_combiner #(.SEGS(K), .PULSE_CYC(3), .EDGE_CNT_W(8), .OVL_CNT_W(3)) dut_w (
    .clk(clk), .rst_n(rst_n), .phase_in(ph),
    .mult_clk_out(o_b), .edge_cnt(e_b), .overlap_cnt(v_b));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int w8(input int v);
    return v & 255;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int base_a, base_b;
    @(negedge clk);
    repeat (3) tick();
    // R1 during reset
    chk("R1 out in reset", o_a == 1'b0 && o_b == 1'b0, o_a, 0);
    chk("R1 edge_cnt in reset", e_a == 0 && e_b == 0, e_a, 0);
    chk("R1 overlap_cnt in reset", v_a == 0 && v_b == 0, v_a, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 after release", o_a == 0 && e_a == 0 && v_a == 0, e_a, 0);

    // R2 R3 R4 R5: each phase alone
    for (int i = 0; i < N; i++) begin
      base_a = e_a;
      base_b = e_b;
      ph[i] = 1'b1;
      tick();
      tick();
      chk($sformatf("R2 no early pulse phase %0d", i), o_a == 0, o_a, 0);
      tick();
      chk($sformatf("R5 pulse from phase %0d", i), o_a == 1, o_a, 1);
      chk($sformatf("R7 edge step phase %0d", i), e_a == w8(base_a + 1), e_a, w8(base_a + 1));
      chk($sformatf("R2 wide dut rises phase %0d", i), o_b == 1, o_b, 1);
      tick();
      chk($sformatf("R3 width 1 ends phase %0d", i), o_a == 0, o_a, 0);
      chk($sformatf("R3 width 3 cycle 2 phase %0d", i), o_b == 1, o_b, 1);
      tick();
      chk($sformatf("R3 width 3 cycle 3 phase %0d", i), o_b == 1, o_b, 1);
      tick();
      chk($sformatf("R3 width 3 ends phase %0d", i), o_b == 0, o_b, 0);
      chk($sformatf("R7 wide edge step phase %0d", i), e_b == w8(base_b + 1), e_b, w8(base_b + 1));
      ph[i] = 1'b0;
      repeat (5) tick();
      chk($sformatf("R4 fall no pulse phase %0d", i), o_a == 0 && o_b == 0, o_a, 0);
      chk($sformatf("R4 fall no count phase %0d", i), e_a == w8(base_a + 1), e_a, w8(base_a + 1));
    end

    // R6 R10: evenly spread rotation, sweep of spacings
    for (int s = 2; s <= 6; s++) begin
      int p, reps, hi_a, hi_b, va0, vb0;
      p = N * s;
      reps = 3;
      base_a = e_a;
      base_b = e_b;
      va0 = v_a;
      vb0 = v_b;
      hi_a = 0;
      hi_b = 0;
      for (int t = 0; t < reps * p; t++) begin
        for (int i = 0; i < N; i++)
          ph[i] = (t >= i * s) && (((t - i * s) % p) < (p / 2));
        tick();
        if (o_a) hi_a++;
        if (o_b) hi_b++;
      end
      ph = '0;
      for (int t = 0; t < 8; t++) begin
        tick();
        if (o_a) hi_a++;
        if (o_b) hi_b++;
      end
      chk($sformatf("R6 edges spacing %0d", s), e_a == w8(base_a + N * reps), e_a, w8(base_a + N * reps));
      chk($sformatf("R3 high cycles spacing %0d", s), hi_a == N * reps, hi_a, N * reps);
      chk($sformatf("R10 no overlap spacing %0d", s), v_a == va0, v_a, va0);
      if (s >= 4) begin
        chk($sformatf("R6 wide edges spacing %0d", s), e_b == w8(base_b + N * reps), e_b, w8(base_b + N * reps));
        chk($sformatf("R3 wide high cycles spacing %0d", s), hi_b == 3 * N * reps, hi_b, 3 * N * reps);
        chk($sformatf("R10 wide no overlap spacing %0d", s), v_b == vb0, v_b, vb0);
      end
    end

    // R8 R9: coincident phases merge, overlap count saturates at 7
    for (int r = 0; r < 9; r++) begin
      int exp_v;
      base_a = e_a;
      ph[3] = 1'b1;
      ph[11] = 1'b1;
      repeat (3) tick();
      chk($sformatf("R8 merged pulse high rep %0d", r), o_a == 1, o_a, 1);
      tick();
      chk($sformatf("R8 single pulse rep %0d", r), o_a == 0, o_a, 0);
      ph = '0;
      repeat (4) tick();
      chk($sformatf("R8 one edge rep %0d", r), e_a == w8(base_a + 1), e_a, w8(base_a + 1));
      exp_v = (r + 1 > 7) ? 7 : r + 1;
      chk($sformatf("R9 overlap count rep %0d", r), v_a == exp_v, v_a, exp_v);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule